// File: doc/BRIEF.md
# Masked Per-Chain Group Signature Checker

This block runs the first phase of at-speed scan diagnosis: it works out which pattern groups hold errors, without capturing every response bit. A bank of multiple-input signature registers (one single-input MISR per analyzer) sits behind a chain mask. For the length of one pattern group, each analyzer compacts exactly one scan chain, chosen by its own select field. Several groups on different chains are therefore checked in the same BIST run. At the end of the group the signatures are sent out one bit at a time on a single serial port, paced by a slow tester-rate strobe. Each outgoing bit is compared against an expected bit that the tester supplies in lockstep. Any mismatch marks that analyzer's group as failing.

A `start` pulse clears every MISR and every fail flag, and latches the select fields. The next `GROUP_LEN` clock edges compact the selected chains at full speed. The readout then runs analyzer by analyzer, most significant bit first. When the last bit has been compared, `done` rises and the flags stay valid until the next group starts. Seeding the pattern generator and storing the expected signatures are handled outside this block.

States: IDLE (after reset), COMPACT, READOUT and DONE. The transitions are:
- IDLE→COMPACT on an accepted `start`.
- COMPACT→READOUT on the last compaction edge.
- READOUT→DONE on the strobe that carries the final bit.
- DONE→COMPACT on the next `start`.

Top module: `group_sig_checker`

## Requirements
- R1: After reset the block is in IDLE, with `done`=0, `ser_valid`=0, `ser_out`=0 and `grp_fail` all zero.
- R2: Analyzer k compacts only the chain whose index is held in `chain_sel[k*SEL_W +: SEL_W]`, sampled on the accepted `start` edge. Activity on chains that are not selected, and later changes to `chain_sel`, have no effect on any signature.
- R3: An accepted `start` clears every MISR to zero. On each of the following `GROUP_LEN` edges each MISR updates as next = {s[62:0],0} XOR (s[63] ? 64'h1B : 0) XOR {63'b0, din}, which is the polynomial x^64+x^4+x^3+x+1.
- R4: Readout sends analyzer 0 first, then analyzer 1 and so on, each from bit 63 down to bit 0. `ser_out` shows the current bit, and each `shift_tick` high on a clock edge in READOUT advances the readout by one bit. `shift_tick` is ignored in every other state.
- R5: `grp_fail[k]` is 1 exactly when at least one of analyzer k's 64 readout bits differed from `exp_bit` on its strobe edge. A group with no mismatch is never flagged. An accepted `start` clears all flags.
- R6: `done` rises on the edge that consumes the last readout bit. It stays high, with `grp_fail` unchanged, until the next accepted `start`, which drops it at once.
- R7: `start` is accepted only in IDLE or DONE. A `start` seen during COMPACT or READOUT neither restarts nor clears anything.
- R8: `ser_valid` is high exactly while the block is in READOUT. Its first cycle is the one after the last compaction edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | At-speed test clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a pattern group (accepted in IDLE or DONE) |
| chain_sel | input | NUM_SA*SEL_W | Per-analyzer chain index, latched on start |
| chain_bits | input | NUM_CHAINS | Scan-out bit of every chain this cycle |
| shift_tick | input | 1 | Tester-rate strobe that advances the readout |
| exp_bit | input | 1 | Expected signature bit for the current readout position |
| ser_out | output | 1 | Serial signature bit being read out |
| ser_valid | output | 1 | High while the readout is in progress |
| done | output | 1 | Group check complete; flags valid |
| grp_fail | output | NUM_SA | Per-analyzer failing-group flag |

## Verification
The bench goes after several corner cases, each chosen because a specific design error would show up in it:
- A group long enough for bit 63 to feed back. A wrong or missing tap term would corrupt every later readout bit.
- Mismatches placed at the most significant bit, the least significant bit and the middle of different analyzers. An off-by-one in the readout index, or a flag stored against the wrong analyzer, would flag the wrong group.
- Both analyzers on one chain, select values changed after `start`, and the only selected chain held at zero while all the others toggle. A mask that leaks other chains, or that reads a live select instead of the latched one, would produce a non-zero or wrong signature.
- Stray `start` and `shift_tick` pulses in the middle of compaction. A design that accepts them would restart the group or begin the readout early.

// File: rtl/gsc_pkg.sv
package gsc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COMPACT = 2'd1,
        ST_READOUT = 2'd2,
        ST_DONE    = 2'd3
    } gsc_state_e;

endpackage

// File: rtl/gsc_chain_mask.sv
module gsc_chain_mask #(
    parameter int NUM_CHAINS = 8,
    parameter int NUM_SA     = 2,
    parameter int SEL_W      = 3
) (
    input  logic [NUM_CHAINS-1:0]   chain_bits,
    input  logic [NUM_SA*SEL_W-1:0] sel,
    output logic [NUM_SA-1:0]       tap
);

    // one chain per analyzer; out-of-range selects feed a zero
    for (genvar k = 0; k < NUM_SA; k++) begin : g_tap
        always_comb begin
            tap[k] = 1'b0;
            for (int c = 0; c < NUM_CHAINS; c++) begin
                if (int'(sel[k*SEL_W +: SEL_W]) == c) tap[k] = chain_bits[c];
            end
        end
    end

endmodule

// File: rtl/gsc_misr.sv
module gsc_misr #(
    parameter int              SIG_W   = 64,
    parameter logic [SIG_W-1:0] FB_POLY = {{(SIG_W-5){1'b0}}, 5'h1B}
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic             din,
    output logic [SIG_W-1:0] sig
);

    logic [SIG_W-1:0] nxt;

    always_comb begin
        nxt    = {sig[SIG_W-2:0], 1'b0} ^ (sig[SIG_W-1] ? FB_POLY : '0);
        nxt[0] = nxt[0] ^ din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   sig <= '0;
        else if (clr) sig <= '0;
        else if (en)  sig <= nxt;
    end

endmodule

// File: rtl/group_sig_checker.sv
module group_sig_checker
    import gsc_pkg::*;
#(
    parameter int NUM_CHAINS = 8,
    parameter int NUM_SA     = 2,
    parameter int SIG_W      = 64,   // power of two
    parameter int GROUP_LEN  = 80,
    parameter int SEL_W      = (NUM_CHAINS > 1) ? $clog2(NUM_CHAINS) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [NUM_SA*SEL_W-1:0] chain_sel,
    input  logic [NUM_CHAINS-1:0]   chain_bits,
    input  logic                    shift_tick,
    input  logic                    exp_bit,
    output logic                    ser_out,
    output logic                    ser_valid,
    output logic                    done,
    output logic [NUM_SA-1:0]       grp_fail
);

    localparam int LOG_SIG = $clog2(SIG_W);
    localparam int TOTAL   = NUM_SA * SIG_W;
    localparam int CNT_W   = $clog2(TOTAL + 1);
    localparam int HI_W    = CNT_W - LOG_SIG;
    localparam int GL_W    = $clog2(GROUP_LEN + 1);
    localparam logic [SIG_W-1:0] FB_POLY = {{(SIG_W-5){1'b0}}, 5'h1B};

    gsc_state_e               state_q, state_d;
    logic [NUM_SA*SEL_W-1:0]  sel_q;
    logic [GL_W-1:0]          gcnt_q;
    logic [CNT_W-1:0]         rcnt_q;
    logic [NUM_SA-1:0]        fail_q;
    logic [NUM_SA-1:0]        tap;
    logic [SIG_W-1:0]         sig [NUM_SA];
    logic [SIG_W-1:0]         cur_sig;
    logic [HI_W-1:0]          ana_sel;
    logic [LOG_SIG-1:0]       pos;
    logic                     ser_bit;
    logic                     accept, compacting, last_cmp, rd_step, rd_last;

    assign accept     = start && (state_q == ST_IDLE || state_q == ST_DONE);
    assign compacting = (state_q == ST_COMPACT);
    assign last_cmp   = compacting && (gcnt_q == GL_W'(GROUP_LEN - 1));
    assign rd_step    = (state_q == ST_READOUT) && shift_tick;
    assign rd_last    = rd_step && (rcnt_q == CNT_W'(TOTAL - 1));
    assign ana_sel    = rcnt_q[CNT_W-1:LOG_SIG];
    assign pos        = rcnt_q[LOG_SIG-1:0];

    // ---------------- datapath submodules ----------------
    gsc_chain_mask #(
        .NUM_CHAINS (NUM_CHAINS),
        .NUM_SA     (NUM_SA),
        .SEL_W      (SEL_W)
    ) u_mask (
        .chain_bits (chain_bits),
        .sel        (sel_q),
        .tap        (tap)
    );

    for (genvar k = 0; k < NUM_SA; k++) begin : g_sa
        gsc_misr #(
            .SIG_W   (SIG_W),
            .FB_POLY (FB_POLY)
        ) u_misr (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (accept),
            .en    (compacting),
            .din   (tap[k]),
            .sig   (sig[k])
        );
    end

    // ---------------- next-state logic ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (accept)  state_d = ST_COMPACT;
            ST_COMPACT: if (last_cmp) state_d = ST_READOUT;
            ST_READOUT: if (rd_last) state_d = ST_DONE;
            ST_DONE:    if (accept)  state_d = ST_COMPACT;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- counters, select latch, flags ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q  <= '0;
            gcnt_q <= '0;
            rcnt_q <= '0;
            fail_q <= '0;
        end else if (accept) begin
            sel_q  <= chain_sel;
            gcnt_q <= '0;
            rcnt_q <= '0;
            fail_q <= '0;
        end else begin
            if (compacting) gcnt_q <= gcnt_q + 1'b1;
            if (rd_step) begin
                rcnt_q <= rcnt_q + 1'b1;
                for (int k = 0; k < NUM_SA; k++) begin
                    if (int'(ana_sel) == k && ser_bit != exp_bit) fail_q[k] <= 1'b1;
                end
            end
        end
    end

    // ---------------- readout bit select ----------------
    always_comb begin
        cur_sig = '0;
        for (int k = 0; k < NUM_SA; k++) begin
            if (int'(ana_sel) == k) cur_sig = sig[k];
        end
        ser_bit = cur_sig[~pos];
    end

    // ---------------- outputs ----------------
    always_comb begin
        ser_valid = (state_q == ST_READOUT);
        done      = (state_q == ST_DONE);
        ser_out   = ser_valid ? ser_bit : 1'b0;
        grp_fail  = fail_q;
    end

endmodule

// File: rtl/group_sig_checker_chk.sv
module group_sig_checker_chk #(
    parameter int NUM_SA = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              shift_tick,
    input logic              ser_valid,
    input logic              done,
    input logic [NUM_SA-1:0] grp_fail
);

    assert_done_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(grp_fail)));

    assert_flags_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start) |=> (grp_fail == '0 && !done));

    assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_valid && start) |=> (ser_valid || done));

    assert_tick_paces_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_valid && !shift_tick) |=> ser_valid);

    assert_valid_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(ser_valid && done));

    assert_idle_no_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && !ser_valid && !$past(done)) |-> (grp_fail == '0));

endmodule

bind group_sig_checker group_sig_checker_chk #(.NUM_SA(NUM_SA)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .shift_tick (shift_tick),
    .ser_valid  (ser_valid),
    .done       (done),
    .grp_fail   (grp_fail)
);

// File: tb/group_sig_checker_tb.sv
module group_sig_checker_tb;

    localparam int NC = 8;
    localparam int NSA = 2;
    localparam int SW = 64;
    localparam int GL = 80;
    localparam int SLW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [NSA*SLW-1:0] chain_sel = '0;
    logic [NC-1:0] chain_bits = '0;
    logic shift_tick = 1'b0;
    logic exp_bit = 1'b0;
    logic ser_out, ser_valid, done;
    logic [NSA-1:0] grp_fail;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    group_sig_checker #(.NUM_CHAINS(NC), .NUM_SA(NSA), .SIG_W(SW), .GROUP_LEN(GL)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .chain_sel(chain_sel),
        .chain_bits(chain_bits), .shift_tick(shift_tick), .exp_bit(exp_bit),
        .ser_out(ser_out), .ser_valid(ser_valid), .done(done), .grp_fail(grp_fail)
    );

    // {poke, flip_pos[5:0], flip_ana, flip_en, seed[15:0], sel1[2:0], sel0[2:0]}
    localparam int NV = 5;
    localparam logic [30:0] VEC [NV] = '{
        {1'b0, 6'd0,  1'b0, 1'b0, 16'hACE1, 3'd2, 3'd5},
        {1'b0, 6'd63, 1'b0, 1'b1, 16'h1234, 3'd7, 3'd0},
        {1'b0, 6'd0,  1'b1, 1'b1, 16'hBEEF, 3'd3, 3'd3},
        {1'b1, 6'd0,  1'b0, 1'b0, 16'h5A5A, 3'd1, 3'd7},
        {1'b0, 6'd31, 1'b0, 1'b1, 16'h0F0F, 3'd4, 3'd6}
    };

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] misr_model(input logic [63:0] s, input logic b);
        logic [63:0] n;
        n = {s[62:0], 1'b0} ^ (s[63] ? 64'h1B : 64'h0);
        n[0] = n[0] ^ b;
        return n;
    endfunction

    function automatic logic [15:0] lf(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    task automatic run_group(input logic [2:0] s0, input logic [2:0] s1, input logic [15:0] seed,
                             input logic [NC-1:0] hold, input bit flip, input bit fana,
                             input logic [5:0] fpos, input bit poke, input int gap);
        logic [63:0] m [NSA];
        logic [15:0] r;
        logic [NC-1:0] d;
        logic [NSA-1:0] efail;
        logic [NSA-1:0] fsnap;
        m[0] = '0; m[1] = '0; r = seed; efail = '0;
        @(negedge clk);
        chain_sel = {s1, s0};
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chain_sel = {~s1, ~s0};   // later changes must not matter (R2)
        check(!done && grp_fail == '0, "R6 R5 start clears done/flags", {62'b0, done, |grp_fail}, 64'h0);
        for (int i = 0; i < GL; i++) begin
            d = (r[7:0] ^ r[15:8]) & ~hold;
            r = lf(r);
            chain_bits = d;
            m[0] = misr_model(m[0], d[s0]);
            m[1] = misr_model(m[1], d[s1]);
            if (poke && i == 10) begin start = 1'b1; shift_tick = 1'b1; end
            if (poke && i == 11) begin start = 1'b0; shift_tick = 1'b0; end
            @(negedge clk);
        end
        check(ser_valid && !done, "R8 ser_valid after compaction", {63'b0, ser_valid}, 64'h1);
        for (int j = 0; j < NSA*SW; j++) begin
            int a = j / SW;
            int p = SW - 1 - (j % SW);
            logic e;
            bit f;
            e = m[a][p];
            f = flip && (a == int'(fana)) && (p == int'(fpos));
            if (f) efail[a] = 1'b1;
            check(ser_out === e, "R3 R4 serial signature bit", {63'b0, ser_out}, {63'b0, e});
            exp_bit = e ^ f;
            shift_tick = 1'b1;
            @(negedge clk);
            shift_tick = 1'b0;
            exp_bit = 1'b0;
            if (j != NSA*SW - 1) begin
                check(ser_valid, "R8 valid during readout", {63'b0, ser_valid}, 64'h1);
                repeat (gap) @(negedge clk);
            end
        end
        check(done && !ser_valid, "R6 done after last bit", {62'b0, done, ser_valid}, 64'h2);
        check(grp_fail == efail, "R5 group fail flags", {62'b0, grp_fail}, {62'b0, efail});
        fsnap = grp_fail;
        shift_tick = 1'b1;
        repeat (4) @(negedge clk);
        shift_tick = 1'b0;
        check(done && grp_fail == fsnap, "R6 R4 flags hold, tick ignored in DONE", {62'b0, grp_fail}, {62'b0, fsnap});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!done && !ser_valid && grp_fail == '0 && ser_out == 1'b0, "R1 reset state",
              {60'b0, done, ser_valid, ser_out, |grp_fail}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        shift_tick = 1'b1;
        @(negedge clk);
        shift_tick = 1'b0;
        check(!ser_valid && !done, "R1 R4 tick ignored in IDLE", {62'b0, ser_valid, done}, 64'h0);

        // table-driven groups (R2 R3 R4 R5 R7)
        for (int v = 0; v < NV; v++) begin
            run_group(VEC[v][2:0], VEC[v][5:3], VEC[v][21:6], '0, VEC[v][22], VEC[v][23],
                      VEC[v][29:24], VEC[v][30], 1 + (v % 3));
        end

        // directed: only selected chain held low while others toggle -> zero signature (R2)
        run_group(3'd0, 3'd0, 16'hFFFF, 8'h01, 1'b0, 1'b0, 6'd0, 1'b0, 2);
        // directed: error at LSB of last analyzer with both on top chain, no gap
        run_group(3'd7, 3'd7, 16'h8001, '0, 1'b1, 1'b1, 6'd0, 1'b1, 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule